// File: doc/BRIEF.md
# PCI Host Bridge Window Translator

This block sits between a CPU-side slave port and the request side of a PCI host controller. Every CPU transaction is sorted by address into one of three windows, each reachable through two physical aliases: a control window, an I/O window and a memory window. The control window is served locally. It holds the bridge's own 256-byte configuration header, a configuration address register, two rebasing registers and a data port that turns CPU word accesses into PCI configuration cycles.

Accesses to the I/O and memory windows are not served locally. The block adds the matching base register to the window offset and forwards the result as a single request to the PCI side. That request carries a kind, a direction, an address, a byte size and write data, and it waits for an acknowledge that returns read data. Only one transaction is in flight at a time. The CPU side holds `cpu_valid` until the block raises `cpu_ready` for one cycle.

Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. Request kinds are 1 for memory, 2 for I/O and 3 for configuration. Window bases and sizes are parameters. The defaults are listed below.

Top module: `pci_window_bridge`

## Requirements
- R1: An address outside all six window ranges completes with `cpu_ready` and read data 0, and issues no PCI request. The ranges are: control, 0x224 bytes at 0x1E200000 and 0xFE200000; I/O, 0x40000 bytes at 0x1E240000 and 0xFE240000; memory, 0x1000000 bytes at 0x1D000000 and 0xFD000000.
- R2: Word-aligned control offsets 0x000 to 0x0FC read and write the 64-word configuration header. After reset, word 0x04 reads 0x02900080 and every other header word reads 0.
- R3: Control offset 0x1C0 is the configuration address register. It is readable and writable, and it resets to 0.
- R4: Control offsets 0x1C4 (memory base) and 0x1C8 (I/O base) can be written but always read 0. Both bases reset to 0.
- R5: A memory-window access issues a kind-1 request. Its address is the window offset plus the memory base, and its size, direction and write data are those of the CPU access. A read returns the PCI read data.
- R6: An I/O-window access issues a kind-2 request. Its address is the window offset plus the I/O base, and it otherwise behaves as in R5.
- R7: A word access to control offset 0x220 issues a kind-3, size-2 request at the address held in the configuration address register. A read returns the PCI read data.
- R8: Control offsets that are not decoded, including misaligned ones, read 0. Writes to them change no state.
- R9: A control-window access whose size is not 2 completes with read data 0. It writes nothing and forwards nothing, even at offset 0x220.
- R10: While a PCI request waits for `pci_req_ready`, its fields stay stable. `cpu_ready` rises in the cycle after the acknowledge and lasts exactly one cycle. A request and a completion never coincide.
- R11: The two aliases of each window behave the same way for the same window offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU access request, held until completion |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_write | input | 1 | 1 for a write access |
| cpu_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| cpu_addr | input | 32 | CPU physical address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| pci_req_valid | output | 1 | PCI-side request pending |
| pci_req_ready | input | 1 | PCI-side acknowledge |
| pci_req_kind | output | 2 | Request kind (1 memory, 2 I/O, 3 configuration) |
| pci_req_write | output | 1 | Request direction, 1 for write |
| pci_req_addr | output | 32 | Translated PCI address or port number |
| pci_req_size | output | 2 | Request size code |
| pci_req_wdata | output | 32 | Request write data |
| pci_rsp_rdata | input | 32 | PCI read data, taken with `pci_req_ready` |

## Verification
A wrong base register or a wrong configuration address never shows up when the register is read, because the bases read 0 by design. The error appears only as a shifted `pci_req_addr` on the next forwarded access, one cycle after the CPU request is taken. For that reason the bench checks every forwarded address rather than relying on readback. A corrupted header word, or a write that leaked through a sub-word or undecoded access, stays hidden until that word is read. Each such case is therefore followed by a read of the word it could have touched. A stuck transaction state shows up within one cycle, as a missing or doubled `cpu_ready` pulse or as a request that overlaps a completion.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_CTRL = 2'd1,
    WIN_IO   = 2'd2,
    WIN_MEM  = 2'd3
  } win_e;

  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_HDR,
    SLOT_CADDR,
    SLOT_MBASE,
    SLOT_IBASE,
    SLOT_PORT
  } slot_e;

  localparam logic [1:0] PK_MEM = 2'd1;
  localparam logic [1:0] PK_IO  = 2'd2;
  localparam logic [1:0] PK_CFG = 2'd3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // true when addr lies in [base, base + span)
  function automatic logic win_hit(input logic [ADDR_W-1:0] addr,
                                   input logic [ADDR_W-1:0] base,
                                   input logic [ADDR_W-1:0] span);
    logic [ADDR_W:0] diff;
    diff = {1'b0, addr} - {1'b0, base};
    return !diff[ADDR_W] && (diff[ADDR_W-1:0] < span);
  endfunction

  function automatic logic [ADDR_W-1:0] win_offset(input logic [ADDR_W-1:0] addr,
                                                   input logic [ADDR_W-1:0] base);
    return addr - base;
  endfunction

  // window offset to PCI-side address, wrapping at 32 bits
  function automatic logic [ADDR_W-1:0] rebase(input logic [ADDR_W-1:0] off,
                                               input logic [ADDR_W-1:0] base);
    return off + base;
  endfunction
endpackage

// File: rtl/pwb_decode.sv
module pwb_decode
  import pwb_pkg::*;
#(
  parameter logic [31:0] CTRL_BASE_A = 32'h1E20_0000,
  parameter logic [31:0] CTRL_BASE_B = 32'hFE20_0000,
  parameter logic [31:0] CTRL_SPAN   = 32'h0000_0224,
  parameter logic [31:0] IO_BASE_A   = 32'h1E24_0000,
  parameter logic [31:0] IO_BASE_B   = 32'hFE24_0000,
  parameter logic [31:0] IO_SPAN     = 32'h0004_0000,
  parameter logic [31:0] MEM_BASE_A  = 32'h1D00_0000,
  parameter logic [31:0] MEM_BASE_B  = 32'hFD00_0000,
  parameter logic [31:0] MEM_SPAN    = 32'h0100_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [ADDR_W-1:0] offset
);
  localparam int NWIN   = 3;
  localparam int NALIAS = 2;
  localparam int NRANGE = NWIN * NALIAS;

  localparam logic [31:0] BASES [NRANGE] = '{CTRL_BASE_A, CTRL_BASE_B,
                                             IO_BASE_A,   IO_BASE_B,
                                             MEM_BASE_A,  MEM_BASE_B};
  localparam logic [31:0] SPANS [NWIN]   = '{CTRL_SPAN, IO_SPAN, MEM_SPAN};

  logic [NRANGE-1:0] hit;
  logic [ADDR_W-1:0] offs [NRANGE];

  for (genvar g = 0; g < NRANGE; g++) begin : g_range
    assign hit[g]  = win_hit(addr, BASES[g], SPANS[g / NALIAS]);
    assign offs[g] = win_offset(addr, BASES[g]);
  end

  // lowest range index wins should parameters ever overlap
  always_comb begin
    win    = WIN_NONE;
    offset = '0;
    for (int g = NRANGE - 1; g >= 0; g--) begin
      if (hit[g]) begin
        win    = win_e'(2'(g / NALIAS + 1));
        offset = offs[g];
      end
    end
  end
endmodule

// File: rtl/pwb_regs.sv
module pwb_regs
  import pwb_pkg::*;
#(
  parameter int          HDR_BYTES  = 256,
  parameter logic [31:0] CADDR_OFF  = 32'h0000_01C0,
  parameter logic [31:0] MBASE_OFF  = 32'h0000_01C4,
  parameter logic [31:0] IBASE_OFF  = 32'h0000_01C8,
  parameter logic [31:0] PORT_OFF   = 32'h0000_0220,
  parameter logic [31:0] HDR_W1_RST = 32'h0290_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] off,
  output slot_e             slot,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [ADDR_W-1:0] mem_base,
  output logic [ADDR_W-1:0] io_base
);
  localparam int HDR_WORDS = HDR_BYTES / 4;
  localparam int IDX_W     = $clog2(HDR_WORDS);

  logic [DATA_W-1:0] hdr_q [HDR_WORDS];
  logic [IDX_W-1:0]  idx;

  function automatic slot_e slot_of(input logic [ADDR_W-1:0] o);
    if (o[1:0] != 2'b00)       return SLOT_NONE;
    if (o < 32'(HDR_BYTES))    return SLOT_HDR;
    if (o == CADDR_OFF)        return SLOT_CADDR;
    if (o == MBASE_OFF)        return SLOT_MBASE;
    if (o == IBASE_OFF)        return SLOT_IBASE;
    if (o == PORT_OFF)         return SLOT_PORT;
    return SLOT_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] hdr_reset(input int w);
    return (w == 1) ? HDR_W1_RST : '0;
  endfunction

  assign slot = slot_of(off);
  assign idx  = off[IDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < HDR_WORDS; w++) hdr_q[w] <= hdr_reset(w);
    end else if (wr_en && slot == SLOT_HDR) begin
      hdr_q[idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      mem_base <= '0;
      io_base  <= '0;
    end else if (wr_en) begin
      case (slot)
        SLOT_CADDR: cfg_addr <= wr_data;
        SLOT_MBASE: mem_base <= wr_data;
        SLOT_IBASE: io_base  <= wr_data;
        default: ;
      endcase
    end
  end

  // bases are write-only: they fall to the zero default
  always_comb begin
    case (slot)
      SLOT_HDR:   rd_data = hdr_q[idx];
      SLOT_CADDR: rd_data = cfg_addr;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwb_xact.sv
module pwb_xact
  import pwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [1:0]        cpu_size,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  win_e              win,
  input  logic [ADDR_W-1:0] offset,
  input  slot_e             slot,
  input  logic [DATA_W-1:0] reg_rd_data,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] io_base,
  output logic              reg_wr_en,
  output logic              acc_start,
  output logic              pci_req_valid,
  input  logic              pci_req_ready,
  output logic [1:0]        pci_req_kind,
  output logic              pci_req_write,
  output logic [ADDR_W-1:0] pci_req_addr,
  output logic [1:0]        pci_req_size,
  output logic [DATA_W-1:0] pci_req_wdata,
  input  logic [DATA_W-1:0] pci_rsp_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_FWD, S_RESP} state_e;

  state_e            state;
  logic              ctrl_word;
  logic              fwd_go;
  logic [1:0]        fwd_kind;
  logic [1:0]        fwd_size;
  logic [ADDR_W-1:0] fwd_addr;
  logic [DATA_W-1:0] local_rd;
  logic [DATA_W-1:0] rdata_q;

  assign acc_start = (state == S_IDLE) && cpu_valid;
  assign ctrl_word = (win == WIN_CTRL) && (cpu_size == SZ_WORD);
  assign fwd_go    = acc_start && ((win == WIN_IO) || (win == WIN_MEM) ||
                                   (ctrl_word && slot == SLOT_PORT));
  assign reg_wr_en = acc_start && ctrl_word && cpu_write && (slot != SLOT_PORT);
  assign local_rd  = (ctrl_word && !cpu_write) ? reg_rd_data : '0;

  always_comb begin
    case (win)
      WIN_MEM: begin
        fwd_kind = PK_MEM;
        fwd_addr = rebase(offset, mem_base);
        fwd_size = cpu_size;
      end
      WIN_IO: begin
        fwd_kind = PK_IO;
        fwd_addr = rebase(offset, io_base);
        fwd_size = cpu_size;
      end
      default: begin
        fwd_kind = PK_CFG;
        fwd_addr = cfg_addr;
        fwd_size = SZ_WORD;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      pci_req_kind  <= '0;
      pci_req_write <= 1'b0;
      pci_req_addr  <= '0;
      pci_req_size  <= '0;
      pci_req_wdata <= '0;
      rdata_q       <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (fwd_go) begin
            state         <= S_FWD;
            pci_req_kind  <= fwd_kind;
            pci_req_write <= cpu_write;
            pci_req_addr  <= fwd_addr;
            pci_req_size  <= fwd_size;
            pci_req_wdata <= cpu_wdata;
          end else if (acc_start) begin
            state   <= S_RESP;
            rdata_q <= local_rd;
          end
        end
        S_FWD: begin
          if (pci_req_ready) begin
            state   <= S_RESP;
            rdata_q <= pci_req_write ? '0 : pci_rsp_rdata;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pci_req_valid = (state == S_FWD);
  assign cpu_ready     = (state == S_RESP);
  assign cpu_rdata     = rdata_q;
endmodule

// File: rtl/pci_window_bridge.sv
module pci_window_bridge
  import pwb_pkg::*;
#(
  parameter logic [31:0] CTRL_BASE_A = 32'h1E20_0000,
  parameter logic [31:0] CTRL_BASE_B = 32'hFE20_0000,
  parameter logic [31:0] CTRL_SPAN   = 32'h0000_0224,
  parameter logic [31:0] IO_BASE_A   = 32'h1E24_0000,
  parameter logic [31:0] IO_BASE_B   = 32'hFE24_0000,
  parameter logic [31:0] IO_SPAN     = 32'h0004_0000,
  parameter logic [31:0] MEM_BASE_A  = 32'h1D00_0000,
  parameter logic [31:0] MEM_BASE_B  = 32'hFD00_0000,
  parameter logic [31:0] MEM_SPAN    = 32'h0100_0000,
  parameter int          HDR_BYTES   = 256,
  parameter logic [31:0] HDR_W1_RST  = 32'h0290_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  output logic        cpu_ready,
  input  logic        cpu_write,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        pci_req_valid,
  input  logic        pci_req_ready,
  output logic [1:0]  pci_req_kind,
  output logic        pci_req_write,
  output logic [31:0] pci_req_addr,
  output logic [1:0]  pci_req_size,
  output logic [31:0] pci_req_wdata,
  input  logic [31:0] pci_rsp_rdata
);
  // named internal events, also observed by the bound checker
  win_e              dec_win;
  logic [ADDR_W-1:0] dec_offset;
  slot_e             reg_slot;
  logic [DATA_W-1:0] reg_rd_data;
  logic              reg_wr_en;
  logic              acc_start;
  logic [ADDR_W-1:0] cfg_addr;
  logic [ADDR_W-1:0] mem_base;
  logic [ADDR_W-1:0] io_base;

  pwb_decode #(
    .CTRL_BASE_A(CTRL_BASE_A), .CTRL_BASE_B(CTRL_BASE_B), .CTRL_SPAN(CTRL_SPAN),
    .IO_BASE_A(IO_BASE_A),     .IO_BASE_B(IO_BASE_B),     .IO_SPAN(IO_SPAN),
    .MEM_BASE_A(MEM_BASE_A),   .MEM_BASE_B(MEM_BASE_B),   .MEM_SPAN(MEM_SPAN)
  ) u_decode (
    .addr   (cpu_addr),
    .win    (dec_win),
    .offset (dec_offset)
  );

  pwb_regs #(
    .HDR_BYTES  (HDR_BYTES),
    .HDR_W1_RST (HDR_W1_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .off      (dec_offset),
    .slot     (reg_slot),
    .rd_data  (reg_rd_data),
    .wr_en    (reg_wr_en),
    .wr_data  (cpu_wdata),
    .cfg_addr (cfg_addr),
    .mem_base (mem_base),
    .io_base  (io_base)
  );

  pwb_xact u_xact (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_valid     (cpu_valid),
    .cpu_write     (cpu_write),
    .cpu_size      (cpu_size),
    .cpu_wdata     (cpu_wdata),
    .cpu_ready     (cpu_ready),
    .cpu_rdata     (cpu_rdata),
    .win           (dec_win),
    .offset        (dec_offset),
    .slot          (reg_slot),
    .reg_rd_data   (reg_rd_data),
    .cfg_addr      (cfg_addr),
    .mem_base      (mem_base),
    .io_base       (io_base),
    .reg_wr_en     (reg_wr_en),
    .acc_start     (acc_start),
    .pci_req_valid (pci_req_valid),
    .pci_req_ready (pci_req_ready),
    .pci_req_kind  (pci_req_kind),
    .pci_req_write (pci_req_write),
    .pci_req_addr  (pci_req_addr),
    .pci_req_size  (pci_req_size),
    .pci_req_wdata (pci_req_wdata),
    .pci_rsp_rdata (pci_rsp_rdata)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
  import pwb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ready,
  input logic [1:0]  cpu_size,
  input logic [31:0] cpu_rdata,
  input logic        pci_req_valid,
  input logic        pci_req_ready,
  input logic [1:0]  pci_req_kind,
  input logic [31:0] pci_req_addr,
  input logic [1:0]  pci_req_size,
  input logic [31:0] pci_req_wdata,
  input logic        acc_start,
  input win_e        win,
  input logic [31:0] offset,
  input logic [31:0] cfg_addr,
  input logic [31:0] mem_base,
  input logic [31:0] io_base
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req_valid && !pci_req_ready |=> pci_req_valid && $stable(pci_req_addr) &&
    $stable(pci_req_kind) && $stable(pci_req_wdata) && $stable(pci_req_size)); // R10

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req_valid && pci_req_ready |=> cpu_ready && !pci_req_valid); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R10

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ready && pci_req_valid)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start && win == WIN_NONE |=> cpu_ready && cpu_rdata == 32'h0 && !pci_req_valid); // R1

  AST_CTRL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start && win == WIN_CTRL && cpu_size != SZ_WORD |=>
    cpu_ready && cpu_rdata == 32'h0 && !pci_req_valid); // R9

  AST_MEM_REBASE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start && win == WIN_MEM |=> pci_req_valid && pci_req_kind == PK_MEM &&
    pci_req_addr == $past(offset) + mem_base); // R5

  AST_IO_REBASE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start && win == WIN_IO |=> pci_req_valid && pci_req_kind == PK_IO &&
    pci_req_addr == $past(offset) + io_base); // R6

  AST_CFG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req_valid && pci_req_kind == PK_CFG |->
    pci_req_size == SZ_WORD && pci_req_addr == cfg_addr); // R7
endmodule

bind pci_window_bridge pwb_checker i_pwb_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_ready     (cpu_ready),
  .cpu_size      (cpu_size),
  .cpu_rdata     (cpu_rdata),
  .pci_req_valid (pci_req_valid),
  .pci_req_ready (pci_req_ready),
  .pci_req_kind  (pci_req_kind),
  .pci_req_addr  (pci_req_addr),
  .pci_req_size  (pci_req_size),
  .pci_req_wdata (pci_req_wdata),
  .acc_start     (acc_start),
  .win           (dec_win),
  .offset        (dec_offset),
  .cfg_addr      (cfg_addr),
  .mem_base      (mem_base),
  .io_base       (io_base)
);

// File: tb/test_pci_window_bridge.sv
`timescale 1ns/1ps
module test_pci_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic        cpu_write = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [31:0] cpu_addr = 32'h0;
  logic [31:0] cpu_wdata = 32'h0;
  logic [31:0] cpu_rdata;
  logic        pci_req_valid;
  logic        pci_req_ready = 1'b0;
  logic [1:0]  pci_req_kind;
  logic        pci_req_write;
  logic [31:0] pci_req_addr;
  logic [1:0]  pci_req_size;
  logic [31:0] pci_req_wdata;
  logic [31:0] pci_rsp_rdata = 32'h0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pci_window_bridge i_pci_window_bridge (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        fwd;
    logic [1:0]  kind;
    logic [31:0] paddr;
    logic [31:0] prsp;
    logic [31:0] exp_rd;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b0, 2'd2, 32'h1E200004, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h02900080},        // R2 reset header
    '{4'd2, 1'b0, 2'd2, 32'h1E200000, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R2
    '{4'd3, 1'b0, 2'd2, 32'h1E2001C0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R3 reset
    '{4'd4, 1'b0, 2'd0, 32'h1D000010, 32'h0, 1'b1, 2'd1, 32'h00000010, 32'hAB, 32'hAB},      // R4 base zero
    '{4'd4, 1'b1, 2'd2, 32'h1E2001C4, 32'h40000000, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},        // R4
    '{4'd4, 1'b1, 2'd2, 32'h1E2001C8, 32'h00001000, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},        // R4
    '{4'd4, 1'b0, 2'd2, 32'h1E2001C4, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R4
    '{4'd4, 1'b0, 2'd2, 32'hFE2001C8, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R4
    '{4'd11, 1'b1, 2'd1, 32'hFD000022, 32'h1234, 1'b1, 2'd1, 32'h40000022, 32'h0, 32'h0},    // R11 R5
    '{4'd5, 1'b0, 2'd2, 32'h1DFFFFFC, 32'h0, 1'b1, 2'd1, 32'h40FFFFFC, 32'h89ABCDEF, 32'h89ABCDEF}, // R5
    '{4'd6, 1'b1, 2'd0, 32'h1E240003, 32'h5A, 1'b1, 2'd2, 32'h00001003, 32'h0, 32'h0},       // R6
    '{4'd6, 1'b0, 2'd2, 32'hFE27FFFC, 32'h0, 1'b1, 2'd2, 32'h00040FFC, 32'hCAFEF00D, 32'hCAFEF00D}, // R6
    '{4'd2, 1'b1, 2'd2, 32'h1E200010, 32'hDEADBEEF, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},        // R2
    '{4'd11, 1'b0, 2'd2, 32'hFE200010, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'hDEADBEEF},       // R11
    '{4'd2, 1'b1, 2'd2, 32'h1E2000FC, 32'h0BADF00D, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},        // R2 last word
    '{4'd2, 1'b0, 2'd2, 32'h1E2000FC, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0BADF00D},        // R2
    '{4'd3, 1'b1, 2'd2, 32'h1E2001C0, 32'h80000814, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},        // R3
    '{4'd3, 1'b0, 2'd2, 32'hFE2001C0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h80000814},        // R3
    '{4'd7, 1'b1, 2'd2, 32'h1E200220, 32'h5555AAAA, 1'b1, 2'd3, 32'h80000814, 32'h0, 32'h0}, // R7
    '{4'd7, 1'b0, 2'd2, 32'hFE200220, 32'h0, 1'b1, 2'd3, 32'h80000814, 32'h11223344, 32'h11223344}, // R7
    '{4'd8, 1'b1, 2'd2, 32'h1E200100, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},        // R8
    '{4'd8, 1'b0, 2'd2, 32'h1E200100, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R8
    '{4'd8, 1'b0, 2'd2, 32'h1E200200, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R8
    '{4'd8, 1'b0, 2'd2, 32'h1E200012, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R8 misaligned
    '{4'd9, 1'b1, 2'd0, 32'h1E200010, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R9 byte write
    '{4'd9, 1'b0, 2'd2, 32'h1E200010, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'hDEADBEEF},        // R9 unchanged
    '{4'd9, 1'b0, 2'd1, 32'h1E200004, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R9 half read
    '{4'd9, 1'b1, 2'd1, 32'h1E200220, 32'hFFFF, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},            // R9 port
    '{4'd1, 1'b0, 2'd2, 32'h1E280000, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R1
    '{4'd1, 1'b0, 2'd2, 32'h1E000000, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R1
    '{4'd1, 1'b0, 2'd2, 32'h1E200224, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0},               // R1
    '{4'd1, 1'b0, 2'd2, 32'h1CFFFFFC, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0}                // R1
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    string       req;
    logic        fwd;
    logic        got;
    logic [1:0]  kind, psz;
    logic [31:0] paddr, pwd, rd;
    req = $sformatf("R%0d", v.rq);
    fwd = 1'b0; got = 1'b0;
    kind = '0; psz = '0; paddr = '0; pwd = '0; rd = '0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = v.wr; cpu_size = v.sz;
    cpu_addr = v.addr; cpu_wdata = v.wdata;
    for (int t = 0; t < 40 && !got; t++) begin
      @(negedge clk);
      if (pci_req_valid) begin
        fwd = 1'b1; kind = pci_req_kind; paddr = pci_req_addr;
        psz = pci_req_size; pwd = pci_req_wdata;
        for (int w = 0; w < 2; w++) begin
          @(negedge clk);
          chk("R10", "held request addr", pci_req_addr, paddr);
          chk("R10", "held request valid", {31'h0, pci_req_valid}, 32'h1);
        end
        pci_req_ready = 1'b1; pci_rsp_rdata = v.prsp;
        @(negedge clk);
        pci_req_ready = 1'b0; pci_rsp_rdata = 32'h0;
        chk("R10", "ready after ack", {31'h0, cpu_ready}, 32'h1);
      end
      if (cpu_ready) begin
        got = 1'b1; rd = cpu_rdata;
      end
    end
    cpu_valid = 1'b0;
    chk(req, "completion seen", {31'h0, got}, 32'h1);
    chk(req, "forwarded", {31'h0, fwd}, {31'h0, v.fwd});
    if (v.fwd && fwd) begin
      chk(req, "kind", {30'h0, kind}, {30'h0, v.kind});
      chk(req, "pci addr", paddr, v.paddr);
      chk(req, "pci size", {30'h0, psz}, (v.kind == 2'd3) ? 32'h2 : {30'h0, v.sz});
      if (v.wr) chk(req, "pci wdata", pwd, v.wdata);
    end
    chk(req, "read data", rd, v.exp_rd);
    @(negedge clk);
    chk("R10", "ready is one pulse", {31'h0, cpu_ready}, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R10", "reset cpu_ready", {31'h0, cpu_ready}, 32'h0);
    chk("R10", "reset pci_req_valid", {31'h0, pci_req_valid}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // second reset: stored state reverts (R2, R3, R4)
    do_reset();
    run_vec('{4'd2, 1'b0, 2'd2, 32'h1E200010, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0});        // R2
    run_vec('{4'd2, 1'b0, 2'd2, 32'hFE200004, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h02900080}); // R2
    run_vec('{4'd3, 1'b0, 2'd2, 32'h1E2001C0, 32'h0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0});        // R3
    run_vec('{4'd4, 1'b0, 2'd1, 32'hFD000100, 32'h0, 1'b1, 2'd1, 32'h00000100, 32'h7777, 32'h7777}); // R4
    run_vec('{4'd4, 1'b1, 2'd2, 32'h1E240010, 32'h0F0F0F0F, 1'b1, 2'd2, 32'h00000010, 32'h0, 32'h0}); // R4
    // configuration port at address zero after reset (R7)
    run_vec('{4'd7, 1'b0, 2'd2, 32'h1E200220, 32'h0, 1'b1, 2'd3, 32'h0, 32'h01020304, 32'h01020304}); // R7

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule